// File: doc/BRIEF.md
# Instruction Prefetch Address Generator

This block produces a stream of line-aligned instruction prefetch addresses for a shader core's front end. A one-cycle kernel-start pulse carries the kernel entry address and a line count, and the block then issues a startup burst of consecutive 128-byte lines beginning at the line holding the entry point. At most 256 lines (32 KB) are issued. After the first kernel start, the block also keeps a programmable number of lines (0 to 3) requested beyond the line of the currently executing program counter.

Software can direct extra prefetches with a command. The command carries an absolute target address, or a signed offset that is added to the current program counter, and also a line count. One command is held at a time. The startup burst has priority over software lines, and software lines have priority over sequential run-ahead. A new kernel start drops whatever remains of a software command. Every request leaves through a registered valid/ready port.

Top module: `ipf_prefetch_gen`

## Requirements
- R1: Every request address has its low 7 bits zero; it is the 128-byte line containing the address that produced it.
- R2: A kernel-start pulse with entry address E and count N issues the lines E rounded down to 128 bytes, then +128, and so on, N lines in total; N is capped at 256, and N = 0 issues nothing.
- R3: While a request is valid and ready is low, valid stays high and the address does not change.
- R4: After the first kernel start, with distance D (0 to 3), the block requests each of the lines one to D past the program counter's line exactly once while that line stays put; with D = 0, or before any kernel start, no run-ahead request is made.
- R5: An accepted command with the relative flag low issues L (0 to 15) consecutive lines starting at the line of its target address; L = 0 issues nothing.
- R6: An accepted command with the relative flag high starts at the line of the program counter plus the target field read as a 32-bit two's-complement offset.
- R7: Command ready is low from the cycle after a command with nonzero count is accepted until its last line has entered the output register, and is low in any cycle where the kernel-start pulse is high.
- R8: When several sources have a line pending, startup burst lines go out first, then software lines, then run-ahead lines.
- R9: A kernel-start pulse discards the remaining lines of a software command, and command ready is high in the following cycle unless a second pulse arrives. A request already presented on the output still completes.
- R10: After reset no request is valid and command ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kstart_i | input | 1 | Kernel-start pulse |
| kentry_i | input | 32 | Kernel entry address |
| kburst_i | input | 9 | Startup burst line count (capped at 256) |
| ahead_i | input | 2 | Run-ahead distance in lines |
| pc_i | input | 32 | Currently executing program counter |
| sw_valid_i | input | 1 | Software prefetch command valid |
| sw_ready_o | output | 1 | Software prefetch command accepted when high with valid |
| sw_rel_i | input | 1 | 1: target is an offset from pc_i; 0: absolute address |
| sw_target_i | input | 32 | Absolute address or signed offset |
| sw_lines_i | input | 4 | Number of lines to prefetch |
| req_valid_o | output | 1 | Prefetch request valid |
| req_ready_i | input | 1 | Downstream accepts the request |
| req_addr_o | output | 32 | 128-byte-aligned line address |

## Verification
The hardest case to reach is one where all three sources are pending at the same time and a kernel start arrives while a software line is stuck in the output register. The bench gets there by holding ready low, so requests pile up behind one stalled slot. While it is low, the bench starts a kernel, queues a command and sets up the run-ahead distance. It then releases ready and compares the whole issued order with the expected list. A second run keeps ready low while a software line sits in the output, fires a kernel start, and checks three things: the held line still completes, the burst follows it, and the rest of the command never appears. Random absolute and relative commands under random backpressure then check that line addresses wrap correctly and that commands are refused while one is active.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
    localparam int ADDR_W     = 32;
    localparam int LINE_BYTES = 128;
    localparam int OFFS_W     = $clog2(LINE_BYTES);
    localparam int LINE_W     = ADDR_W - OFFS_W;
    localparam int BURST_MAX  = 256;
    localparam int BURST_W    = $clog2(BURST_MAX + 1);
    localparam int AHEAD_W    = 2;
    localparam int SWCNT_W    = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_BURST = 2'd1,
        SRC_SW    = 2'd2,
        SRC_RA    = 2'd3
    } src_e;

    typedef struct packed {
        logic                rel;
        addr_t               target;
        logic [SWCNT_W-1:0]  lines;
    } swcmd_t;

    function automatic line_t line_of(addr_t a);
        return a[ADDR_W-1:OFFS_W];
    endfunction

    function automatic addr_t addr_of(line_t l);
        return {l, {OFFS_W{1'b0}}};
    endfunction
endpackage

// File: rtl/ipf_seq_src.sv
module ipf_seq_src
    import ipf_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  line_t            load_line,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             take,
    output logic             busy,
    output line_t            line
);
    logic [CNT_W-1:0] left_q;
    line_t            cur_q;

    assign busy = (left_q != '0);
    assign line = cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            cur_q  <= '0;
        end else if (clear) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_cnt;
            cur_q  <= load_line;
        end else if (take && busy) begin
            left_q <= left_q - 1'b1;
            cur_q  <= cur_q + 1'b1;
        end
    end

    AST_TAKE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        take |-> busy); // R8
endmodule

// File: rtl/ipf_runahead.sv
module ipf_runahead
    import ipf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [AHEAD_W-1:0] ahead,
    input  line_t              pc_line,
    input  logic               take,
    output logic               ok,
    output line_t              line
);
    logic  running_q;
    line_t next_q;
    line_t dist_next;
    line_t dist_line;
    line_t ahead_ext;
    logic  in_win;

    assign ahead_ext = line_t'(ahead);
    assign dist_next = next_q - pc_line;
    assign in_win    = (dist_next != '0) && (dist_next <= ahead_ext + 1'b1);
    assign line      = in_win ? next_q : pc_line + 1'b1;
    assign dist_line = line - pc_line;
    assign ok        = running_q && (dist_line <= ahead_ext);

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            next_q    <= '0;
        end else begin
            if (start) running_q <= 1'b1;
            next_q <= take ? line + 1'b1 : line;
        end
    end

    AST_RA_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        take |-> (running_q && ahead != '0)); // R4
endmodule

// File: rtl/ipf_prefetch_gen.sv
module ipf_prefetch_gen
    import ipf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                kstart_i,
    input  logic [31:0]         kentry_i,
    input  logic [8:0]          kburst_i,
    input  logic [1:0]          ahead_i,
    input  logic [31:0]         pc_i,
    input  logic                sw_valid_i,
    output logic                sw_ready_o,
    input  logic                sw_rel_i,
    input  logic [31:0]         sw_target_i,
    input  logic [3:0]          sw_lines_i,
    output logic                req_valid_o,
    input  logic                req_ready_i,
    output logic [31:0]         req_addr_o
);
    swcmd_t             cmd;
    logic               sw_accept;
    addr_t              sw_start;
    logic [BURST_W-1:0] burst_cnt;
    logic               slot_free;
    src_e               pick;
    line_t              pick_line;

    logic  b_busy, s_busy, r_ok;
    line_t b_line, s_line, r_line;

    logic   req_valid_q;
    addr_t  req_addr_q;

    assign cmd        = '{rel: sw_rel_i, target: sw_target_i, lines: sw_lines_i};
    assign sw_ready_o = !s_busy && !kstart_i;
    assign sw_accept  = sw_valid_i && sw_ready_o;
    assign sw_start   = cmd.rel ? (pc_i + cmd.target) : cmd.target;
    assign burst_cnt  = (kburst_i > BURST_W'(BURST_MAX)) ? BURST_W'(BURST_MAX) : kburst_i;
    assign slot_free  = !req_valid_q || req_ready_i;

    always_comb begin
        pick      = SRC_NONE;
        pick_line = '0;
        if (slot_free && !kstart_i) begin
            if (b_busy) begin
                pick      = SRC_BURST;
                pick_line = b_line;
            end else if (s_busy) begin
                pick      = SRC_SW;
                pick_line = s_line;
            end else if (r_ok) begin
                pick      = SRC_RA;
                pick_line = r_line;
            end
        end
    end

    ipf_seq_src #(.CNT_W(BURST_W)) u_burst (
        .clk       (clk),
        .rst       (rst),
        .clear     (1'b0),
        .load      (kstart_i),
        .load_line (line_of(kentry_i)),
        .load_cnt  (burst_cnt),
        .take      (pick == SRC_BURST),
        .busy      (b_busy),
        .line      (b_line)
    );

    ipf_seq_src #(.CNT_W(SWCNT_W)) u_sw (
        .clk       (clk),
        .rst       (rst),
        .clear     (kstart_i),
        .load      (sw_accept),
        .load_line (line_of(sw_start)),
        .load_cnt  (cmd.lines),
        .take      (pick == SRC_SW),
        .busy      (s_busy),
        .line      (s_line)
    );

    ipf_runahead u_ra (
        .clk     (clk),
        .rst     (rst),
        .start   (kstart_i),
        .ahead   (ahead_i),
        .pc_line (line_of(pc_i)),
        .take    (pick == SRC_RA),
        .ok      (r_ok),
        .line    (r_line)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid_q <= 1'b0;
            req_addr_q  <= '0;
        end else if (slot_free) begin
            req_valid_q <= (pick != SRC_NONE);
            if (pick != SRC_NONE) req_addr_q <= addr_of(pick_line);
        end
    end

    assign req_valid_o = req_valid_q;
    assign req_addr_o  = req_addr_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o))); // R3
    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> (req_addr_o[OFFS_W-1:0] == '0)); // R1
    AST_SW_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (sw_valid_i && sw_ready_o && sw_lines_i != '0) |=> !sw_ready_o); // R7
    AST_KSTART_DROP: assert property (@(posedge clk) disable iff (rst)
        kstart_i |=> (kstart_i || sw_ready_o)); // R9
endmodule

// File: tb/ipf_prefetch_gen_tb.sv
module ipf_prefetch_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        kstart = 1'b0;
    logic [31:0] kentry = '0;
    logic [8:0]  kburst = '0;
    logic [1:0]  ahead = '0;
    logic [31:0] pc = '0;
    logic        sw_valid = 1'b0;
    logic        sw_ready;
    logic        sw_rel = 1'b0;
    logic [31:0] sw_target = '0;
    logic [3:0]  sw_lines = '0;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [31:0] req_addr;

    int tests = 0;
    int fails = 0;
    bit rdy_rand = 1'b0;
    bit rdy_fixed = 1'b1;
    logic [31:0] obs[$];
    logic [31:0] exp_q[$];
    logic        prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipf_prefetch_gen u_dut (
        .clk(clk), .rst(rst), .kstart_i(kstart), .kentry_i(kentry),
        .kburst_i(kburst), .ahead_i(ahead), .pc_i(pc),
        .sw_valid_i(sw_valid), .sw_ready_o(sw_ready), .sw_rel_i(sw_rel),
        .sw_target_i(sw_target), .sw_lines_i(sw_lines),
        .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (rdy_rand) req_ready = ($urandom % 4) != 0;
        else          req_ready = rdy_fixed;
    end

    // Monitor: sampled on the falling edge, between driving and capture.
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall)
                chk(req_valid && req_addr == prev_addr, "R3 hold", req_addr, prev_addr);
            if (req_valid)
                chk(req_addr[6:0] == 7'd0, "R1 aligned", req_addr, req_addr & ~32'h7f);
            if (req_valid && req_ready) obs.push_back(req_addr);
            prev_stall = req_valid && !req_ready;
            prev_addr  = req_addr;
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic kick(logic [31:0] e, logic [8:0] n);
        kentry = e; kburst = n; kstart = 1'b1;
        tick(1);
        kstart = 1'b0;
    endtask

    task automatic send_sw(bit rel, logic [31:0] tgt, logic [3:0] n);
        sw_rel = rel; sw_target = tgt; sw_lines = n; sw_valid = 1'b1;
        @(negedge clk);
        while (!sw_ready) @(negedge clk);
        @(posedge clk);
        #2;
        sw_valid = 1'b0;
    endtask

    task automatic expect_run(logic [31:0] a, int n);
        for (int k = 0; k < n; k++) exp_q.push_back((a & ~32'h7f) + 32'(k) * 32'd128);
    endtask

    task automatic compare(string req);
        chk(obs.size() == exp_q.size(), {req, " count"}, obs.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < obs.size(); i++)
            chk(obs[i] == exp_q[i], req, obs[i], exp_q[i]);
        obs.delete();
        exp_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        tick(3);
        rst = 1'b0;
        @(negedge clk);
        chk(!req_valid, "R10 valid", req_valid, 0);
        chk(sw_ready, "R10 sw_ready", sw_ready, 1);
        tick(1);

        // R5 absolute command, R4 no run-ahead before any kernel start
        ahead = 2'd2; pc = 32'h0000_4000;
        send_sw(1'b0, 32'h0000_5055, 4'd3);
        expect_run(32'h0000_5055, 3);
        tick(20);
        compare("R5/R4 absolute before start");
        send_sw(1'b0, 32'h0000_6000, 4'd0);
        tick(10);
        compare("R5 zero count");

        // R2 bursts
        ahead = 2'd0;
        kick(32'h1000_0043, 9'd5);
        expect_run(32'h1000_0043, 5);
        tick(20);
        compare("R2 burst 5");
        kick(32'h2000_0000, 9'd0);
        tick(10);
        compare("R2 burst 0");
        kick(32'h3000_0000, 9'd300);
        expect_run(32'h3000_0000, 256);
        tick(280);
        compare("R2 burst capped");

        // R6 relative
        pc = 32'h0000_2010;
        send_sw(1'b1, 32'hffff_ff00, 4'd2);
        expect_run(32'h0000_1f10, 2);
        tick(15);
        compare("R6 relative negative");

        // R7 refusal while busy
        rdy_fixed = 1'b0; tick(1);
        send_sw(1'b0, 32'h0000_7000, 4'd4);
        @(negedge clk);
        chk(!sw_ready, "R7 busy refuse", sw_ready, 0);
        tick(3);
        @(negedge clk);
        chk(!sw_ready, "R7 still busy under stall", sw_ready, 0);
        rdy_fixed = 1'b1;
        expect_run(32'h0000_7000, 4);
        tick(15);
        @(negedge clk);
        chk(sw_ready, "R7 ready after drain", sw_ready, 1);
        compare("R7 lines");

        // R4 run-ahead
        pc = 32'h0000_3000; ahead = 2'd3;
        expect_run(32'h0000_3080, 3);
        tick(25);
        compare("R4 window no repeat");
        pc = 32'h0000_3080;
        exp_q.push_back(32'h0000_3200);
        tick(15);
        compare("R4 pc advance");
        ahead = 2'd0;
        pc = 32'h0000_9000;
        tick(10);
        compare("R4 distance zero");

        // R8 priority with all sources pending behind a stall
        rdy_fixed = 1'b0; tick(1);
        ahead = 2'd0; pc = 32'h0000_C000;
        kick(32'h0000_A000, 9'd3);
        tick(2);
        send_sw(1'b0, 32'h0000_B000, 4'd2);
        ahead = 2'd2;
        tick(3);
        rdy_fixed = 1'b1;
        expect_run(32'h0000_A000, 3);
        expect_run(32'h0000_B000, 2);
        expect_run(32'h0000_C080, 2);
        tick(25);
        compare("R8 priority order");
        ahead = 2'd0; tick(2);

        // R9 kernel start drops pending software lines
        rdy_fixed = 1'b0; tick(1);
        send_sw(1'b0, 32'h0000_8000, 4'd10);
        tick(3);
        kick(32'h0000_9000, 9'd2);
        @(negedge clk);
        chk(sw_ready, "R9 ready after start", sw_ready, 1);
        tick(2);
        rdy_fixed = 1'b1;
        exp_q.push_back(32'h0000_8000);
        expect_run(32'h0000_9000, 2);
        tick(30);
        compare("R9 abort");

        // Random software commands under random backpressure (R5, R6)
        rdy_rand = 1'b1;
        for (int n = 0; n < 40; n++) begin
            bit          rel = $urandom % 2;
            logic [31:0] p   = $urandom;
            logic [31:0] t   = rel ? (32'($urandom % 65536) - 32'd32768) : $urandom;
            logic [3:0]  c   = 4'(1 + $urandom % 8);
            pc = p;
            send_sw(rel, t, c);
            expect_run(rel ? p + t : t, int'(c));
        end
        tick(200);
        compare("R5/R6 random");
        rdy_rand = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule